// File: doc/BRIEF.md
# Adaptive Compressed-Allocation Predictor

This block chooses, for a second-level cache, whether each newly allocated line is stored compressed or uncompressed. The cache is 8-way set-associative with LRU replacement. A set holds at most four uncompressed lines but up to eight compressed ones. The block watches every cache reference and weighs what compression earned against what it cost. The result is kept in one global signed saturating counter. While that counter is zero or positive, the block asks for compressed allocation.

Each reference arrives as a one-cycle strobe with four fields: hit or miss, the LRU stack position of a hit, whether the referenced line is held compressed, and, for a miss, whether the line would still have been resident had the set been fully compressed. A combinational classifier sorts the reference into one of four classes: a hit that only compression made possible, a miss that compression could have avoided, a hit that paid a needless decompression, or a neutral reference. Non-neutral classes are staged, together with the weight they carry, by a two-state update controller. The controller has state UPD_IDLE (nothing staged) and state UPD_APPLY (one staged update that the counter applies this cycle). It moves from UPD_IDLE to UPD_APPLY on a strobed non-neutral reference. It stays in UPD_APPLY while such references keep arriving on consecutive cycles, and returns from UPD_APPLY to UPD_IDLE on a cycle without one. Synchronous reset forces UPD_IDLE.

Top module: `cmp_alloc_predictor`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0 and is shown as 0 on `pred_counter` from that edge on, with `alloc_compressed` high.
- R2: A strobed hit whose `ref_depth` is 4 to 7 (stack positions 5 to 8, beyond the four uncompressed ways) adds `miss_weight` to the counter, whether or not `ref_line_compressed` is set.
- R3: A strobed hit whose `ref_depth` is 0 to 3 with `ref_line_compressed` high subtracts `decomp_weight` from the counter.
- R4: A strobed miss (`ref_hit` low) with `ref_fits_compressed` high adds `miss_weight` to the counter.
- R5: The counter is unchanged by a shallow hit (`ref_depth` 0 to 3) on an uncompressed line, by a miss with `ref_fits_compressed` low, and by any field values while `ref_valid` is low.
- R6: The counter is 19 bits, two's complement, and clamps at +262143 instead of wrapping.
- R7: The counter clamps at -262144 instead of wrapping.
- R8: `alloc_compressed` is high exactly when the counter is zero or positive. At zero it is high.
- R9: A reference sampled at rising edge k changes `pred_counter` at edge k+1. The weights are taken at edge k. References on consecutive cycles are all applied, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | One reference this cycle |
| ref_hit | input | 1 | 1 = hit, 0 = miss |
| ref_depth | input | 3 | LRU stack position of the hit, 0 = most recent |
| ref_line_compressed | input | 1 | Hit line is held in compressed form |
| ref_fits_compressed | input | 1 | Missing line would have been resident under full compression |
| miss_weight | input | 12 | Unsigned credit for an avoided or avoidable miss |
| decomp_weight | input | 12 | Unsigned debit for a needless decompression |
| alloc_compressed | output | 1 | 1 = allocate new lines compressed |
| pred_counter | output | 19 | Current signed counter value |

## Verification
The properties assume that `ref_valid` is held low during reset and that the four reference fields and both weights are known whenever `ref_valid` is high. The stack position is taken as meaningful only on hits. The bench drives inputs only on falling edges. It lowers the strobe before it releases reset, and it keeps the weights within their 12-bit ports. This lets one reference with maximum weight move the counter by at most 4095. Long runs of maximum-weight references are used on purpose to drive the counter into both clamps.

// File: rtl/cmp_pred_pkg.sv
package cmp_pred_pkg;

    typedef enum logic [1:0] {
        RC_NONE      = 2'd0,
        RC_AVOIDED   = 2'd1,
        RC_AVOIDABLE = 2'd2,
        RC_PENALTY   = 2'd3
    } ref_class_e;

    typedef enum logic {
        UPD_IDLE  = 1'b0,
        UPD_APPLY = 1'b1
    } upd_state_e;

endpackage

// File: rtl/cmp_ref_classifier.sv
module cmp_ref_classifier
    import cmp_pred_pkg::*;
#(
    parameter int ASSOC       = 8,
    parameter int UNCOMP_WAYS = 4,
    parameter int DEPTH_W     = $clog2(ASSOC)
) (
    input  logic               hit,
    input  logic [DEPTH_W-1:0] depth,
    input  logic               line_compressed,
    input  logic               fits_compressed,
    output ref_class_e         ref_class
);
    localparam logic [DEPTH_W-1:0] FIRST_DEEP = DEPTH_W'(UNCOMP_WAYS);

    always_comb begin
        ref_class = RC_NONE;
        if (hit) begin
            if (depth >= FIRST_DEEP) begin
                // only a compressed set could keep a line this deep
                ref_class = RC_AVOIDED;
            end else if (line_compressed) begin
                // would have hit anyway; the decompression was wasted
                ref_class = RC_PENALTY;
            end
        end else if (fits_compressed) begin
            ref_class = RC_AVOIDABLE;
        end
    end
endmodule

// File: rtl/cmp_upd_ctrl.sv
module cmp_upd_ctrl
    import cmp_pred_pkg::*;
#(
    parameter int WGT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  ref_class_e       ref_class,
    input  logic [WGT_W-1:0] miss_weight,
    input  logic [WGT_W-1:0] decomp_weight,
    output logic             apply_en,
    output logic             apply_up,
    output logic [WGT_W-1:0] apply_mag
);
    upd_state_e       state_q, state_nx;
    ref_class_e       stage_class_q;
    logic [WGT_W-1:0] stage_mag_q;
    logic             take;

    assign take = ref_valid && (ref_class != RC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UPD_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            UPD_IDLE:  state_nx = take ? UPD_APPLY : UPD_IDLE;
            UPD_APPLY: state_nx = take ? UPD_APPLY : UPD_IDLE;
            default:   state_nx = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_class_q <= RC_NONE;
            stage_mag_q   <= '0;
        end else if (take) begin
            stage_class_q <= ref_class;
            stage_mag_q   <= (ref_class == RC_PENALTY) ? decomp_weight : miss_weight;
        end
    end

    always_comb begin
        apply_en  = 1'b0;
        apply_up  = 1'b0;
        apply_mag = '0;
        unique case (state_q)
            UPD_IDLE: begin
                apply_en = 1'b0;
            end
            UPD_APPLY: begin
                apply_en  = 1'b1;
                apply_up  = (stage_class_q != RC_PENALTY);
                apply_mag = stage_mag_q;
            end
            default: begin
                apply_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/cmp_sat_counter.sv
module cmp_sat_counter #(
    parameter int CNT_W = 19,
    parameter int WGT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             apply_en,
    input  logic             apply_up,
    input  logic [WGT_W-1:0] apply_mag,
    output logic [CNT_W-1:0] cnt
);
    localparam int EXT_W = CNT_W + 2;
    localparam logic signed [EXT_W-1:0] MAX_V = {3'b000, {(CNT_W-1){1'b1}}};
    localparam logic signed [EXT_W-1:0] MIN_V = {3'b111, {(CNT_W-1){1'b0}}};

    logic signed [EXT_W-1:0] cur_ext, mag_ext, sum_ext;
    logic        [CNT_W-1:0] cnt_nx;

    assign cur_ext = {{2{cnt[CNT_W-1]}}, cnt};
    assign mag_ext = {{(EXT_W-WGT_W){1'b0}}, apply_mag};
    assign sum_ext = apply_up ? (cur_ext + mag_ext) : (cur_ext - mag_ext);

    always_comb begin
        if (sum_ext > MAX_V) begin
            cnt_nx = MAX_V[CNT_W-1:0];
        end else if (sum_ext < MIN_V) begin
            cnt_nx = MIN_V[CNT_W-1:0];
        end else begin
            cnt_nx = sum_ext[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (apply_en) begin
            cnt <= cnt_nx;
        end
    end
endmodule

// File: rtl/cmp_alloc_predictor.sv
module cmp_alloc_predictor
    import cmp_pred_pkg::*;
#(
    parameter int ASSOC       = 8,
    parameter int UNCOMP_WAYS = 4,
    parameter int CNT_W       = 19,
    parameter int WGT_W       = 12,
    parameter int DEPTH_W     = $clog2(ASSOC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ref_valid,
    input  logic               ref_hit,
    input  logic [DEPTH_W-1:0] ref_depth,
    input  logic               ref_line_compressed,
    input  logic               ref_fits_compressed,
    input  logic [WGT_W-1:0]   miss_weight,
    input  logic [WGT_W-1:0]   decomp_weight,
    output logic               alloc_compressed,
    output logic [CNT_W-1:0]   pred_counter
);
    ref_class_e       ref_class;
    logic             apply_en, apply_up;
    logic [WGT_W-1:0] apply_mag;
    logic [CNT_W-1:0] cnt;

    cmp_ref_classifier #(
        .ASSOC(ASSOC), .UNCOMP_WAYS(UNCOMP_WAYS), .DEPTH_W(DEPTH_W)
    ) u_cls (
        .hit(ref_hit), .depth(ref_depth),
        .line_compressed(ref_line_compressed),
        .fits_compressed(ref_fits_compressed),
        .ref_class(ref_class)
    );

    cmp_upd_ctrl #(.WGT_W(WGT_W)) u_ctrl (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_class(ref_class),
        .miss_weight(miss_weight), .decomp_weight(decomp_weight),
        .apply_en(apply_en), .apply_up(apply_up), .apply_mag(apply_mag)
    );

    cmp_sat_counter #(.CNT_W(CNT_W), .WGT_W(WGT_W)) u_cnt (
        .clk(clk), .rst(rst), .apply_en(apply_en), .apply_up(apply_up),
        .apply_mag(apply_mag), .cnt(cnt)
    );

    assign pred_counter     = cnt;
    assign alloc_compressed = ~cnt[CNT_W-1];
endmodule

// File: rtl/cmp_alloc_predictor_chk.sv
module cmp_alloc_predictor_chk #(
    parameter int UNCOMP_WAYS = 4,
    parameter int CNT_W       = 19,
    parameter int WGT_W       = 12,
    parameter int DEPTH_W     = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               ref_valid,
    input logic               ref_hit,
    input logic [DEPTH_W-1:0] ref_depth,
    input logic               ref_line_compressed,
    input logic               ref_fits_compressed,
    input logic [WGT_W-1:0]   miss_weight,
    input logic [WGT_W-1:0]   decomp_weight,
    input logic               alloc_compressed,
    input logic [CNT_W-1:0]   pred_counter
);
    localparam logic [DEPTH_W-1:0] FIRST_DEEP = DEPTH_W'(UNCOMP_WAYS);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (pred_counter == '0));

    // R2
    deep_hit_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_hit && ref_depth >= FIRST_DEEP)
        |=> ##1 ($signed(pred_counter) >= $signed($past(pred_counter))));

    // R3
    decomp_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && ref_hit && ref_depth < FIRST_DEEP && ref_line_compressed)
        |=> ##1 ($signed(pred_counter) <= $signed($past(pred_counter))));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ref_valid || (ref_hit && ref_depth < FIRST_DEEP && !ref_line_compressed)
         || (!ref_hit && !ref_fits_compressed))
        |=> ##1 $stable(pred_counter));

    // R8
    alloc_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(alloc_compressed) |-> !$stable(pred_counter));
endmodule

bind cmp_alloc_predictor cmp_alloc_predictor_chk #(
    .UNCOMP_WAYS(UNCOMP_WAYS), .CNT_W(CNT_W), .WGT_W(WGT_W), .DEPTH_W(DEPTH_W)
) u_chk (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_hit(ref_hit),
    .ref_depth(ref_depth), .ref_line_compressed(ref_line_compressed),
    .ref_fits_compressed(ref_fits_compressed), .miss_weight(miss_weight),
    .decomp_weight(decomp_weight), .alloc_compressed(alloc_compressed),
    .pred_counter(pred_counter)
);

// File: tb/tb_cmp_alloc_predictor.sv
module tb_cmp_alloc_predictor;
    localparam int CNT_W = 19;
    localparam int WGT_W = 12;
    localparam int DEPTH_W = 3;
    localparam int CMAX = 262143;
    localparam int CMIN = -262144;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_valid = 1'b0, ref_hit = 1'b0, ref_line_compressed = 1'b0, ref_fits_compressed = 1'b0;
    logic [DEPTH_W-1:0] ref_depth = '0;
    logic [WGT_W-1:0] miss_weight = '0, decomp_weight = '0;
    logic alloc_compressed;
    logic [CNT_W-1:0] pred_counter;

    int checks = 0;
    int fails = 0;
    int model = 0;
    int pend_q[$];
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_alloc_predictor dut (
        .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_hit(ref_hit),
        .ref_depth(ref_depth), .ref_line_compressed(ref_line_compressed),
        .ref_fits_compressed(ref_fits_compressed), .miss_weight(miss_weight),
        .decomp_weight(decomp_weight), .alloc_compressed(alloc_compressed),
        .pred_counter(pred_counter)
    );

    function automatic int cnt_val();
        return int'($signed(pred_counter));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural model: each strobe queues its effect, applied one edge later
    always @(posedge clk) begin
        if (rst) begin
            model = 0;
            pend_q.delete();
        end else begin
            if (pend_q.size() > 0) begin
                model = model + pend_q.pop_front();
                if (model > CMAX) model = CMAX;
                if (model < CMIN) model = CMIN;
            end
            if (ref_valid) begin
                if (ref_hit && ref_depth >= 4) pend_q.push_back(int'(miss_weight));
                else if (ref_hit && ref_line_compressed) pend_q.push_back(-int'(decomp_weight));
                else if (!ref_hit && ref_fits_compressed) pend_q.push_back(int'(miss_weight));
                else pend_q.push_back(0);
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R9 per-cycle counter", cnt_val(), model);
            chk("R8 per-cycle alloc", int'(alloc_compressed), (model >= 0) ? 1 : 0);
        end
    end

    task automatic put(input logic h, input int d, input logic lc, input logic fc,
                       input int mw, input int dw);
        @(negedge clk);
        ref_valid = 1'b1; ref_hit = h; ref_depth = DEPTH_W'(d);
        ref_line_compressed = lc; ref_fits_compressed = fc;
        miss_weight = WGT_W'(mw); decomp_weight = WGT_W'(dw);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_valid = 1'b0;
        end
    endtask

    task automatic one(input logic h, input int d, input logic lc, input logic fc,
                       input int mw, input int dw);
        put(h, d, lc, fc, mw, dw);
        idle(2);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset counter", cnt_val(), 0);
        chk("R1 reset alloc", int'(alloc_compressed), 1);

        // R2 deep hits, including the boundary position 5 and a flag-low line
        one(1, 5, 1, 0, 100, 9);
        chk("R2 deep hit", cnt_val(), 100);
        one(1, 4, 0, 0, 7, 9);
        chk("R2 boundary depth", cnt_val(), 107);

        // R3 shallow compressed hits, down through zero
        one(1, 3, 1, 0, 900, 50);
        chk("R3 needless decompression", cnt_val(), 57);
        one(1, 0, 1, 0, 900, 57);
        chk("R3 to zero", cnt_val(), 0);
        chk("R8 zero allocates compressed", int'(alloc_compressed), 1);
        one(1, 0, 1, 0, 900, 1);
        chk("R3 below zero", cnt_val(), -1);
        chk("R8 negative allocates uncompressed", int'(alloc_compressed), 0);

        // R4 avoidable miss
        one(0, 6, 1, 1, 10, 300);
        chk("R4 avoidable miss", cnt_val(), 9);
        chk("R8 back to compressed", int'(alloc_compressed), 1);

        // R5 neutral references
        one(1, 3, 0, 1, 500, 500);
        chk("R5 shallow uncompressed hit", cnt_val(), 9);
        one(0, 7, 1, 0, 500, 500);
        chk("R5 unavoidable miss", cnt_val(), 9);
        @(negedge clk);
        ref_valid = 1'b0; ref_hit = 1'b1; ref_depth = 3'd6; miss_weight = 12'd800;
        idle(2);
        chk("R5 no strobe", cnt_val(), 9);

        // R9 back-to-back references with changing weights
        put(1, 7, 1, 0, 5, 0);
        put(0, 0, 0, 1, 5, 0);
        put(1, 1, 1, 0, 0, 3);
        idle(2);
        chk("R9 consecutive references", cnt_val(), 16);

        // R6 upper clamp
        for (int i = 0; i < 80; i++) put(1, 6, 1, 0, 4095, 0);
        idle(2);
        chk("R6 clamp high", cnt_val(), CMAX);
        one(0, 0, 0, 1, 4095, 0);
        chk("R6 stays at max", cnt_val(), CMAX);

        // R7 lower clamp
        for (int i = 0; i < 140; i++) put(1, 2, 1, 0, 0, 4095);
        idle(2);
        chk("R7 clamp low", cnt_val(), CMIN);
        chk("R8 at min", int'(alloc_compressed), 0);
        one(1, 1, 1, 0, 0, 4095);
        chk("R7 stays at min", cnt_val(), CMIN);
        one(1, 5, 1, 0, 20, 0);
        chk("R7 leaves min", cnt_val(), CMIN + 20);

        // R1 reset in mid-run with a pending reference
        put(1, 6, 1, 0, 300, 0);
        @(negedge clk);
        ref_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        idle(2);
        chk("R1 mid-run reset", cnt_val(), 0);
        chk("R1 mid-run alloc", int'(alloc_compressed), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule